// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing front end of a serial memory that sits on a two-wire bus as a slave. It brings the clock line and the data line into the system clock domain and detects START and STOP conditions on them. It shifts bytes in and out MSB first and checks the first byte of each transfer against a 4-bit type code and three chip-enable pins. It drives the acknowledge bit and only ever pulls the data line low, as an open-drain output.

Toward the memory controller it offers a byte interface with these signals:
- a strobe for each received byte;
- a request for the next byte to transmit;
- the master's acknowledge status;
- pulses for START, repeated START and STOP;
- a per-byte acknowledge enable.

Two side inputs shape its behaviour. A programming-busy input makes the block ignore the bus entirely while an internal write is in progress. A write-lock input withdraws the acknowledge from write data bytes while still acknowledging the device select and address bytes.

Top module: `twi_slave_front`

## Requirements
- R1: A falling data line while the clock line is high gives a one-cycle `start_evt` if no frame is open, or `rstart_evt` if a frame is open. A rising data line while the clock line is high gives `stop_evt` and closes the frame. At most one of the three pulses is high in any cycle.
- R2: The first byte after a START is matched as type code `TYPE_CODE` (default 4'b1010) in bits 7..4, `dev_pins[2:0]` in bits 3..1, and a read flag in bit 0 (1 = read). On a match the block pulls SDA low for the 9th clock, pulses `sel_stb`, and sets `sel_rd` to bit 0.
- R3: On a mismatch, SDA stays released during the 9th clock. No `rx_stb` or acknowledge follows for any further byte until the next START.
- R4: In a write transfer, each byte after the select byte is shifted in MSB first and presented on `rx_byte` with a one-cycle `rx_stb`. The byte is acknowledged only if `ack_en` is high when its 8th bit is sampled.
- R5: With `wr_lock` high, the select byte and the first `ADDR_BYTES` (default 2) bytes of a write transfer are still acknowledged. Every later byte is not acknowledged, although it is still reported on `rx_byte`.
- R6: After a matched read select, `tx_byte` is sent MSB first, with a 1 bit sent as a released line. The block releases SDA during the 9th clock and reports the master's bit there through `mst_ack_stb` and `mst_ack` (1 = master pulled low). `tx_req` pulses after the read select is acknowledged and after each acknowledge from the master. A not-acknowledge from the master ends transmission.
- R7: While `prog_busy` is high, the block never drives SDA, reports no START, repeated START or STOP, and acknowledges nothing.
- R8: A START arriving in the middle of a byte abandons that byte and restarts select byte reception.
- R9: During and after reset, SDA is released and every event output is low.
- R10: `sda_oe` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |
| dev_pins | input | 3 | Chip-enable pins compared with select bits 3..1 |
| wr_lock | input | 1 | Withdraws the acknowledge from write data bytes |
| prog_busy | input | 1 | Internal programming cycle in progress; bus ignored |
| ack_en | input | 1 | Acknowledge enable for the byte being received |
| tx_byte | input | 8 | Next byte to transmit, loaded when a byte starts |
| rx_byte | output | 8 | Last byte received in a write transfer |
| rx_stb | output | 1 | One-cycle pulse when `rx_byte` is updated |
| sel_stb | output | 1 | One-cycle pulse on a matched select byte |
| sel_rd | output | 1 | Read flag of the last select byte |
| tx_req | output | 1 | One-cycle request for the next `tx_byte` |
| mst_ack_stb | output | 1 | One-cycle pulse when the master's 9th bit is sampled |
| mst_ack | output | 1 | 1 if the master acknowledged the last transmitted byte |
| start_evt | output | 1 | START pulse |
| rstart_evt | output | 1 | Repeated START pulse |
| stop_evt | output | 1 | STOP pulse |

## Verification
A plain write with a three-byte payload and a read with a repeated START exercise the normal paths. The read with a repeated START separates `start_evt` from `rstart_evt` and shows whether bits are driven on the correct clock falls, through the values read back. Two further write patterns tell apart two reasons for a missing acknowledge: a select byte with the wrong chip-enable bits, and a select byte followed by a byte that also matches but carries no START. The same split is made between an `ack_en` refusal and a `wr_lock` refusal, which must fall only on bytes beyond the address count. A transfer during `prog_busy` and a byte cut short by a new START show whether the front end drops state cleanly.

// File: rtl/twi_fe_pkg.sv
// Shared types for the two-wire slave front end.
// Assumes: one engine per slave address; phases below are the only transfer states.
package twi_fe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // ignoring the bus until a START
        PH_SEL  = 2'd1,   // receiving the select byte
        PH_WR   = 2'd2,   // receiving write bytes
        PH_RD   = 2'd3    // transmitting read bytes
    } twi_phase_e;

endpackage

// File: rtl/twi_line_sync.sv
// Multi-flop synchronizer for one bus line into the system clock domain.
// Assumes: the line idles high, so every stage resets to 1.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], raw};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_bus_cond.sv
// Edge and bus-condition detector on the synchronized lines.
// Assumes: inputs are already synchronized; outputs are single-cycle combinational flags.
module twi_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Decode clock edges and data transitions under a high clock.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/twi_byte_engine.sv
// Byte engine: select matching, byte shifting, acknowledge drive and event pulses.
// Assumes: clock edges and conditions come from twi_bus_cond; bitcnt counts rising
// clock edges within a 9-clock byte slot (values 0..9).
module twi_byte_engine
    import twi_fe_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE  = 4'b1010,
    parameter int         ADDR_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [2:0] dev_pins,
    input  logic       wr_lock,
    input  logic       prog_busy,
    input  logic       ack_en,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output logic [7:0] rx_byte,
    output logic       rx_stb,
    output logic       sel_stb,
    output logic       sel_rd,
    output logic       tx_req,
    output logic       mst_ack_stb,
    output logic       mst_ack,
    output logic       start_evt,
    output logic       rstart_evt,
    output logic       stop_evt
);
    localparam int              CW   = $clog2(ADDR_BYTES + 1) + 1;
    localparam logic [CW-1:0]   WCAP = CW'(ADDR_BYTES);

    twi_phase_e    ph;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    byte_in;
    logic          ack_go;
    logic          rd_nak;
    logic          in_frame;
    logic [CW-1:0] wcnt;
    logic          sel_hit;

    // Byte completed by the current sample, and the select match on it.
    always_comb begin
        byte_in = {shreg[6:0], sda_s};
        sel_hit = (byte_in[7:4] == TYPE_CODE) && (byte_in[3:1] == dev_pins);
    end

    // Transfer state, shifting, acknowledge drive and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph          <= PH_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            ack_go      <= 1'b0;
            rd_nak      <= 1'b0;
            in_frame    <= 1'b0;
            wcnt        <= '0;
            sda_oe      <= 1'b0;
            rx_byte     <= '0;
            rx_stb      <= 1'b0;
            sel_stb     <= 1'b0;
            sel_rd      <= 1'b0;
            tx_req      <= 1'b0;
            mst_ack_stb <= 1'b0;
            mst_ack     <= 1'b0;
            start_evt   <= 1'b0;
            rstart_evt  <= 1'b0;
            stop_evt    <= 1'b0;
        end else begin
            rx_stb      <= 1'b0;
            sel_stb     <= 1'b0;
            tx_req      <= 1'b0;
            mst_ack_stb <= 1'b0;
            start_evt   <= 1'b0;
            rstart_evt  <= 1'b0;
            stop_evt    <= 1'b0;
            if (prog_busy) begin
                ph       <= PH_IDLE;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                in_frame <= 1'b0;
            end else if (start_det) begin
                start_evt  <= !in_frame;
                rstart_evt <= in_frame;
                in_frame   <= 1'b1;
                ph         <= PH_SEL;
                bitcnt     <= '0;
                sda_oe     <= 1'b0;
            end else if (stop_det) begin
                stop_evt <= 1'b1;
                in_frame <= 1'b0;
                ph       <= PH_IDLE;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
            end else if (ph != PH_IDLE) begin
                if (scl_rise) begin
                    if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
                    if (ph == PH_RD) begin
                        if (bitcnt == 4'd8) begin
                            mst_ack_stb <= 1'b1;
                            mst_ack     <= !sda_s;
                            tx_req      <= !sda_s;
                            rd_nak      <= sda_s;
                        end
                    end else begin
                        if (bitcnt < 4'd8) shreg <= byte_in;
                        if (bitcnt == 4'd7) begin
                            if (ph == PH_SEL) begin
                                ack_go  <= sel_hit;
                                sel_stb <= sel_hit;
                                sel_rd  <= sda_s;
                            end else begin
                                rx_byte <= byte_in;
                                rx_stb  <= 1'b1;
                                ack_go  <= ack_en && !(wr_lock && (wcnt >= WCAP));
                            end
                        end
                        if (bitcnt == 4'd8 && ph == PH_SEL && ack_go && sel_rd)
                            tx_req <= 1'b1;
                    end
                end else if (scl_fall) begin
                    if (ph == PH_RD) begin
                        if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= !shreg[6];
                        end else if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                        end else if (bitcnt == 4'd9) begin
                            bitcnt <= '0;
                            if (rd_nak) begin
                                ph     <= PH_IDLE;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= tx_byte;
                                sda_oe <= !tx_byte[7];
                            end
                        end
                    end else begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= ack_go;
                        end else if (bitcnt == 4'd9) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (ph == PH_SEL) begin
                                if (!ack_go) begin
                                    ph <= PH_IDLE;
                                end else if (sel_rd) begin
                                    ph     <= PH_RD;
                                    shreg  <= tx_byte;
                                    sda_oe <= !tx_byte[7];
                                    rd_nak <= 1'b0;
                                end else begin
                                    ph   <= PH_WR;
                                    wcnt <= '0;
                                end
                            end else if (wcnt < WCAP) begin
                                wcnt <= wcnt + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/twi_slave_front.sv
// Top of the two-wire slave front end: synchronizers, condition detector, byte engine.
// Assumes: sda_in is the wired line (including this block's own pull-down) and the
// pad turns sda_oe into an open-drain pull-down.
module twi_slave_front #(
    parameter logic [3:0] TYPE_CODE   = 4'b1010,
    parameter int         ADDR_BYTES  = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] dev_pins,
    input  logic       wr_lock,
    input  logic       prog_busy,
    input  logic       ack_en,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       rx_stb,
    output logic       sel_stb,
    output logic       sel_rd,
    output logic       tx_req,
    output logic       mst_ack_stb,
    output logic       mst_ack,
    output logic       start_evt,
    output logic       rstart_evt,
    output logic       stop_evt
);
    logic scl_sync;
    logic sda_sync;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .raw(scl_in), .q(scl_sync)
    );

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .raw(sda_in), .q(sda_sync)
    );

    twi_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .sda_s(sda_sync),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_byte_engine #(.TYPE_CODE(TYPE_CODE), .ADDR_BYTES(ADDR_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_sync),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .dev_pins(dev_pins), .wr_lock(wr_lock), .prog_busy(prog_busy),
        .ack_en(ack_en), .tx_byte(tx_byte), .sda_oe(sda_oe),
        .rx_byte(rx_byte), .rx_stb(rx_stb), .sel_stb(sel_stb), .sel_rd(sel_rd),
        .tx_req(tx_req), .mst_ack_stb(mst_ack_stb), .mst_ack(mst_ack),
        .start_evt(start_evt), .rstart_evt(rstart_evt), .stop_evt(stop_evt)
    );
endmodule

// File: rtl/twi_slave_front_chk.sv
// Property checker for twi_slave_front, attached by bind.
// Assumes: scl_s is the synchronized clock line inside the top module.
module twi_slave_front_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_busy,
    input logic scl_s,
    input logic sda_oe,
    input logic start_evt,
    input logic rstart_evt,
    input logic stop_evt,
    input logic tx_req,
    input logic sel_rd,
    input logic rx_stb
);
    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({start_evt, rstart_evt, stop_evt})); // R1
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n) prog_busy |=> (!sda_oe && !start_evt && !rstart_evt && !stop_evt)); // R7
    AST_OE_STILL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (scl_s && $past(scl_s) && !$past(prog_busy)) |-> $stable(sda_oe)); // R10
    AST_TXREQ_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) tx_req |-> sel_rd); // R6
    AST_RX_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) rx_stb |-> !sel_rd); // R4
endmodule

bind twi_slave_front twi_slave_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .scl_s(scl_sync),
    .sda_oe(sda_oe), .start_evt(start_evt), .rstart_evt(rstart_evt),
    .stop_evt(stop_evt), .tx_req(tx_req), .sel_rd(sel_rd), .rx_stb(rx_stb)
);

// File: tb/sim_twi_slave_front.sv
// Directed bench: a bus master model drives the lines, monitors count output pulses.
module sim_twi_slave_front;
    localparam int H = 10;   // system clocks per clock-line half period
    localparam int Q = 5;    // setup slot inside the low half

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] dev_pins = 3'b101;
    logic       wr_lock = 1'b0;
    logic       prog_busy = 1'b0;
    logic       ack_en = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic       rx_stb, sel_stb, sel_rd, tx_req, mst_ack_stb, mst_ack;
    logic       start_evt, rstart_evt, stop_evt;

    int checks = 0;
    int errors = 0;
    int n_start = 0, n_rstart = 0, n_stop = 0, n_rx = 0, n_sel = 0, n_txreq = 0, n_mack = 0;
    int n_oe_bad = 0;
    int cyc = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = m_sda & ~sda_oe;

    twi_slave_front u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .dev_pins(dev_pins), .wr_lock(wr_lock), .prog_busy(prog_busy), .ack_en(ack_en),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_stb(rx_stb), .sel_stb(sel_stb),
        .sel_rd(sel_rd), .tx_req(tx_req), .mst_ack_stb(mst_ack_stb), .mst_ack(mst_ack),
        .start_evt(start_evt), .rstart_evt(rstart_evt), .stop_evt(stop_evt)
    );

    // Count output pulses and watch sda_oe against the clock line, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_evt)   n_start++;
            if (rstart_evt)  n_rstart++;
            if (stop_evt)    n_stop++;
            if (rx_stb)      n_rx++;
            if (sel_stb)     n_sel++;
            if (tx_req)      n_txreq++;
            if (mst_ack_stb) n_mack++;
            if (m_scl && prev_scl && (sda_oe != prev_oe)) n_oe_bad++;
        end
        prev_scl = m_scl;
        prev_oe  = sda_oe;
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b0; wait_clk(H);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(Q);
        m_scl = 1'b1; wait_clk(H);
        m_sda = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wait_clk(Q);
            m_scl = 1'b1; wait_clk(H);
            m_scl = 1'b0; wait_clk(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; wait_clk(Q);
        m_scl = 1'b1; wait_clk(H / 2);
        acked = !sda_line;
        wait_clk(H / 2);
        m_scl = 1'b0; wait_clk(Q);
    endtask

    task automatic recv_byte(input bit mack, input logic [7:0] next_tx, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q);
            m_scl = 1'b1; wait_clk(H / 2);
            b[i] = sda_line;
            wait_clk(H / 2);
            m_scl = 1'b0; wait_clk(Q);
        end
        m_sda = !mack; wait_clk(Q);
        m_scl = 1'b1; wait_clk(H / 2);
        tx_byte = next_tx;
        wait_clk(H / 2);
        m_scl = 1'b0;
        m_sda = 1'b1; wait_clk(Q);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R9 sda released after reset", sda_oe, 0);
        chk({start_evt, rstart_evt, stop_evt, rx_stb, tx_req} == 5'b0, "R9 events low after reset",
            {start_evt, rstart_evt, stop_evt, rx_stb, tx_req}, 0);
    endtask

    task automatic t_write();
        bit a;
        bus_start();
        chk(n_start == 1 && n_rstart == 0, "R1 start_evt on first START", n_start, 1);
        send_byte(8'hAA, a);
        chk(a, "R2 select 1010_101_0 acknowledged", a, 1);
        chk(n_sel == 1 && sel_rd == 1'b0, "R2 sel_stb and sel_rd write", {n_sel, sel_rd}, 2);
        send_byte(8'h12, a);
        chk(a && rx_byte == 8'h12, "R4 first write byte", rx_byte, 8'h12);
        send_byte(8'h34, a);
        send_byte(8'h9C, a);
        chk(a && rx_byte == 8'h9C, "R4 third write byte acked", rx_byte, 8'h9C);
        chk(n_rx == 3, "R4 rx_stb count", n_rx, 3);
        bus_stop();
        chk(n_stop == 1, "R1 stop_evt", n_stop, 1);
    endtask

    task automatic t_mismatch();
        bit a;
        int rx0;
        rx0 = n_rx;
        bus_start();
        send_byte(8'hA2, a);
        chk(!a, "R3 wrong chip-enable bits not acked", a, 0);
        send_byte(8'hAA, a);
        chk(!a, "R3 matching byte without START ignored", a, 0);
        chk(n_rx == rx0, "R3 no rx_stb after mismatch", n_rx, rx0);
        bus_stop();
    endtask

    task automatic t_ackdis();
        bit a;
        bus_start();
        send_byte(8'hAA, a);
        chk(a, "R4 select acked with ack_en low later", a, 1);
        ack_en = 1'b0;
        send_byte(8'h55, a);
        chk(!a && rx_byte == 8'h55, "R4 ack_en low gives no ack", a, 0);
        ack_en = 1'b1;
        bus_stop();
    endtask

    task automatic t_wrlock();
        bit a;
        wr_lock = 1'b1;
        bus_start();
        send_byte(8'hAA, a);
        chk(a, "R5 select acked under wr_lock", a, 1);
        send_byte(8'h01, a);
        chk(a, "R5 address byte 1 acked under wr_lock", a, 1);
        send_byte(8'h02, a);
        chk(a, "R5 address byte 2 acked under wr_lock", a, 1);
        send_byte(8'h77, a);
        chk(!a && rx_byte == 8'h77, "R5 data byte not acked under wr_lock", a, 0);
        send_byte(8'h78, a);
        chk(!a, "R5 second data byte not acked", a, 0);
        bus_stop();
        wr_lock = 1'b0;
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] b;
        int rs0, tq0, ma0;
        rs0 = n_rstart; tq0 = n_txreq; ma0 = n_mack;
        tx_byte = 8'h5A;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h00, a);
        send_byte(8'h10, a);
        bus_start();
        chk(n_rstart == rs0 + 1, "R1 rstart_evt on repeated START", n_rstart, rs0 + 1);
        send_byte(8'hAB, a);
        chk(a && sel_rd, "R2 read select acked", {a, sel_rd}, 3);
        recv_byte(1'b1, 8'hC3, b);
        chk(b == 8'h5A, "R6 first read byte", b, 8'h5A);
        chk(mst_ack == 1'b1, "R6 master ack reported", mst_ack, 1);
        recv_byte(1'b0, 8'hFF, b);
        chk(b == 8'hC3, "R6 second read byte", b, 8'hC3);
        chk(mst_ack == 1'b0 && n_mack == ma0 + 2, "R6 master nack reported", mst_ack, 0);
        chk(n_txreq == tq0 + 2, "R6 tx_req count", n_txreq, tq0 + 2);
        bus_stop();
    endtask

    task automatic t_busy();
        bit a;
        int s0, p0;
        s0 = n_start + n_rstart; p0 = n_stop;
        prog_busy = 1'b1;
        bus_start();
        send_byte(8'hAA, a);
        chk(!a, "R7 no ack while busy", a, 0);
        bus_stop();
        chk(n_start + n_rstart == s0 && n_stop == p0, "R7 no events while busy",
            n_start + n_rstart + n_stop, s0 + p0);
        prog_busy = 1'b0;
        wait_clk(H);
    endtask

    task automatic t_abort();
        bit a;
        int rs0;
        rs0 = n_rstart;
        bus_start();
        send_bits(8'hAA, 4);
        bus_start();
        chk(n_rstart == rs0 + 1, "R8 START mid-byte seen", n_rstart, rs0 + 1);
        send_byte(8'hAA, a);
        chk(a, "R8 select after abort acked", a, 1);
        send_byte(8'h44, a);
        chk(a && rx_byte == 8'h44, "R8 write after abort", rx_byte, 8'h44);
        bus_stop();
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write();
        t_mismatch();
        t_ackdis();
        t_wrlock();
        t_read();
        t_busy();
        t_abort();
        chk(n_oe_bad == 0, "R10 sda_oe steady while clock high", n_oe_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule